// File: doc/BRIEF.md
# Frame-to-USB FIFO Write Streamer

This block moves one stored image frame, byte by byte, out of the frame memory bank that is ready for reading and into the FIFO of an external USB device controller. The controller's FIFO runs in asynchronous slave mode. It accepts one byte on each low pulse of its write strobe and reports that it is full on an active-low flag. The streamer builds every write cycle from the system clock in three steps: it drives the data with the bus enable, pulses the strobe low, and holds the data afterwards. It does not start a write while the synchronized flag says the FIFO is full. While it waits, it keeps the current byte and its address unchanged.

The frame buffer controller sends a one-cycle start pulse once a complete frame has been written into a bank. The streamer then fetches bytes through a request/return interface, one request per byte, in ascending address order. It counts each byte into a packet and each packet into a frame. A frame is a whole number of packets. The USB controller commits each full packet to the host on its own, so the streamer drives no packet-end signal. After the last byte of the frame has been written, the streamer pulses frame-done, which releases the bank, and goes idle.

Top module: `usb_fifo_streamer`

## Requirements
- R1: While reset is held and after it is released, `fifo_wr_n` is 1 and `fifo_oe`, `frame_busy`, `frame_done` and `rd_req` are 0. Reset given in the middle of a frame abandons that frame.
- R2: A `frame_go` pulse while idle starts a frame, and `frame_busy` reads 1 from the next cycle. A `frame_go` while busy is ignored: it causes no extra bytes and no extra frame-done.
- R3: Every frame issues exactly one single-cycle `rd_req` per byte. The `rd_addr` values run 0, 1, 2 … FRAME_BYTES-1. The byte written to the FIFO for each request is the `rd_data` returned with `rd_valid` for that request, which may come one or more cycles after the request.
- R4: In each write cycle, `fifo_oe` is 1 with `fifo_wr_n` high for exactly SETUP_CLKS cycles. Then `fifo_wr_n` is 0 for exactly PULSE_CLKS cycles. Then `fifo_oe` stays 1 with `fifo_wr_n` high for exactly HOLD_CLKS cycles. `fifo_data` does not change while `fifo_oe` is 1.
- R5: `fifo_oe` is 1 only inside a write cycle. It is 0 whenever the block is idle.
- R6: `fifo_full_n` (0 = full) passes through a SYNC_STAGES-flop synchronizer. After each strobe there is a gap of SETTLE_CLKS cycles before the flag is sampled again. A write cycle never starts while the synchronized flag reads full, so a FIFO that has filled is never written.
- R7: While the FIFO stays full, no strobe is issued and the pending byte and its address are held. When space returns, writing resumes with that same byte, so no byte is skipped or repeated.
- R8: `frame_done` is a one-cycle pulse. It comes in the cycle after the write cycle of byte FRAME_BYTES-1 ends, with `frame_busy` already 0.
- R9: A frame is FRAME_PKTS packets of 2^PKT_LOG2 bytes. `rd_addr` is the packet index times the packet size plus the offset within the packet. Every frame, including the first after a reset, starts at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_go | input | 1 | One-cycle pulse: a complete frame is ready to send |
| frame_busy | output | 1 | A frame transfer is in progress |
| frame_done | output | 1 | One-cycle pulse: last byte written, bank released |
| rd_req | output | 1 | Request for the byte at `rd_addr` |
| rd_addr | output | PKT_W+PKT_LOG2 | Byte address within the frame |
| rd_valid | input | 1 | `rd_data` holds the requested byte |
| rd_data | input | DATA_W | Returned byte |
| fifo_data | output | DATA_W | Data toward the USB controller FIFO |
| fifo_oe | output | 1 | Output enable for the data pads |
| fifo_wr_n | output | 1 | FIFO write strobe, active low |
| fifo_full_n | input | 1 | FIFO full flag, active low, asynchronous |

## Verification
The hardest case to reach is a stall that lands between two bytes of a packet and lasts for several write cycles. After such a stall the held byte must go out once, with no byte lost and none repeated. The bench reaches this case with a model of the external FIFO whose capacity and drain rate come from each vector. A small capacity with a slow drain makes the flag assert after nearly every byte. A forced full window, opened in the middle of a frame, holds the streamer back far longer than a full write cycle. Every captured byte is compared with its place in the frame, so a skipped or repeated byte shows up.

// File: rtl/usb_fifo_streamer_pkg.sv
// Shared types for the FIFO write streamer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package usb_fifo_streamer_pkg;

    // Transfer sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAITD,
        ST_CHKFULL,
        ST_WRITE
    } xfer_state_t;

    // Phases of one external write cycle
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HOLD,
        PH_SETTLE
    } wr_phase_t;

endpackage

// File: rtl/flag_synchronizer.sv
// Multi-flop synchronizer for one asynchronous level.
// Assumes: STAGES >= 2; the input is a level that stays put for several clocks.
module flag_synchronizer #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First flop samples the asynchronous pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= async_in;
                end
            end else begin : g_next
                // Later flops resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= RST_VAL;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/frame_byte_counter.sv
// Counts bytes into packets and packets into a frame; forms the byte address.
// Assumes: packet size is a power of two; clear and step never coincide.
module frame_byte_counter #(
    parameter int PKT_LOG2   = 10,
    parameter int FRAME_PKTS = 1280,
    localparam int PKT_W     = (FRAME_PKTS > 1) ? $clog2(FRAME_PKTS) : 1,
    localparam int ADDR_W    = PKT_W + PKT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    logic [PKT_LOG2-1:0] byte_q;
    logic [PKT_W-1:0]    pkt_q;
    logic                pkt_end;

    assign pkt_end = (byte_q == {PKT_LOG2{1'b1}});
    assign last    = pkt_end && (pkt_q == PKT_W'(FRAME_PKTS - 1));
    assign addr    = {pkt_q, byte_q};

    // Offset within the packet and packet index, wrapping per packet
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            byte_q <= '0;
            pkt_q  <= '0;
        end else if (step) begin
            byte_q <= byte_q + 1'b1;
            if (pkt_end) pkt_q <= pkt_q + 1'b1;
        end
    end

    AST_PKT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_q <= PKT_W'(FRAME_PKTS - 1)); // R9
endmodule

// File: rtl/fifo_strobe_gen.sv
// Times one asynchronous FIFO write: setup, low strobe, hold, then settle gap.
// Assumes: all phase lengths >= 1; launch only while the generator is idle.
module fifo_strobe_gen
    import usb_fifo_streamer_pkg::*;
#(
    parameter int SETUP_CLKS  = 1,
    parameter int PULSE_CLKS  = 2,
    parameter int HOLD_CLKS   = 1,
    parameter int SETTLE_CLKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    output logic wr_n,
    output logic drive,
    output logic cycle_end
);
    localparam int MAX_AB = (SETUP_CLKS > PULSE_CLKS) ? SETUP_CLKS : PULSE_CLKS;
    localparam int MAX_CD = (HOLD_CLKS > SETTLE_CLKS) ? HOLD_CLKS : SETTLE_CLKS;
    localparam int MAXLEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW     = (MAXLEN > 1) ? $clog2(MAXLEN) : 1;

    wr_phase_t       phase_q, phase_d;
    logic [TW-1:0]   tmr_q, tmr_d;
    logic            wr_n_q, drive_q;

    assign cycle_end = (phase_q == PH_SETTLE) && (tmr_q == '0);
    assign wr_n      = wr_n_q;
    assign drive     = drive_q;

    // Next phase and phase timer
    always_comb begin
        phase_d = phase_q;
        tmr_d   = (tmr_q == '0) ? tmr_q : tmr_q - 1'b1;
        case (phase_q)
            PH_IDLE:   if (launch)        begin phase_d = PH_SETUP;  tmr_d = TW'(SETUP_CLKS - 1);  end
            PH_SETUP:  if (tmr_q == '0)   begin phase_d = PH_LOW;    tmr_d = TW'(PULSE_CLKS - 1);  end
            PH_LOW:    if (tmr_q == '0)   begin phase_d = PH_HOLD;   tmr_d = TW'(HOLD_CLKS - 1);   end
            PH_HOLD:   if (tmr_q == '0)   begin phase_d = PH_SETTLE; tmr_d = TW'(SETTLE_CLKS - 1); end
            PH_SETTLE: if (tmr_q == '0)   begin phase_d = PH_IDLE;   tmr_d = '0;                   end
            default:                      begin phase_d = PH_IDLE;   tmr_d = '0;                   end
        endcase
    end

    // Phase register and glitch-free registered pin drivers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            tmr_q   <= '0;
            wr_n_q  <= 1'b1;
            drive_q <= 1'b0;
        end else begin
            phase_q <= phase_d;
            tmr_q   <= tmr_d;
            wr_n_q  <= (phase_d != PH_LOW);
            drive_q <= (phase_d == PH_SETUP) || (phase_d == PH_LOW) || (phase_d == PH_HOLD);
        end
    end

    // Checker: length of the current low strobe
    logic [TW:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n || wr_n_q) low_run_q <= '0;
        else                  low_run_q <= low_run_q + 1'b1;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n_q) |-> (low_run_q == (TW+1)'(PULSE_CLKS))); // R4
    AST_LAUNCH_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> (phase_q == PH_IDLE)); // R4
    AST_STROBE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n_q |-> drive_q); // R5
endmodule

// File: rtl/usb_fifo_streamer.sv
// Streams one frame from the frame buffer into an external asynchronous
// slave FIFO, one byte per write strobe, gated by the FIFO full flag.
// Assumes: rd_valid comes at least one cycle after rd_req; the external
// controller commits each full packet itself.
module usb_fifo_streamer
    import usb_fifo_streamer_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int PKT_LOG2    = 10,
    parameter int FRAME_PKTS  = 1280,
    parameter int SETUP_CLKS  = 1,
    parameter int PULSE_CLKS  = 2,
    parameter int HOLD_CLKS   = 1,
    parameter int SETTLE_CLKS = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PKT_W      = (FRAME_PKTS > 1) ? $clog2(FRAME_PKTS) : 1,
    localparam int ADDR_W     = PKT_W + PKT_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_go,
    output logic              frame_busy,
    output logic              frame_done,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_oe,
    output logic              fifo_wr_n,
    input  logic              fifo_full_n
);
    xfer_state_t       state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic              done_q;
    logic              full_n_s;
    logic              launch, step, clear, load, finish;
    logic              cycle_end, last;

    flag_synchronizer #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(fifo_full_n), .sync_out(full_n_s)
    );

    frame_byte_counter #(.PKT_LOG2(PKT_LOG2), .FRAME_PKTS(FRAME_PKTS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .addr(rd_addr), .last(last)
    );

    fifo_strobe_gen #(
        .SETUP_CLKS(SETUP_CLKS), .PULSE_CLKS(PULSE_CLKS),
        .HOLD_CLKS(HOLD_CLKS), .SETTLE_CLKS(SETTLE_CLKS)
    ) u_strb (
        .clk(clk), .rst_n(rst_n), .launch(launch),
        .wr_n(fifo_wr_n), .drive(fifo_oe), .cycle_end(cycle_end)
    );

    // Sequencer: fetch a byte, wait for room, write it, advance
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        step    = 1'b0;
        clear   = 1'b0;
        load    = 1'b0;
        finish  = 1'b0;
        case (state_q)
            ST_IDLE:    if (frame_go) begin clear = 1'b1; state_d = ST_FETCH; end
            ST_FETCH:   state_d = ST_WAITD;
            ST_WAITD:   if (rd_valid) begin load = 1'b1; state_d = ST_CHKFULL; end
            ST_CHKFULL: if (full_n_s) begin launch = 1'b1; state_d = ST_WRITE; end
            ST_WRITE:   if (cycle_end) begin
                            if (last) begin finish = 1'b1; state_d = ST_IDLE;  end
                            else      begin step   = 1'b1; state_d = ST_FETCH; end
                        end
            default:    state_d = ST_IDLE;
        endcase
    end

    // State, held byte and frame-done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (load) data_q <= rd_data;
            done_q  <= finish;
        end
    end

    assign rd_req     = (state_q == ST_FETCH);
    assign frame_busy = (state_q != ST_IDLE);
    assign frame_done = done_q;
    assign fifo_data  = data_q;

    AST_LAUNCH_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fifo_oe) |-> $past(full_n_s)); // R6
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_oe && $past(fifo_oe)) |-> $stable(fifo_data)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_busy |-> (!fifo_oe && fifo_wr_n && !rd_req)); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !frame_busy); // R8
    AST_HOLD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHKFULL && $past(state_q == ST_CHKFULL)) |-> ($stable(rd_addr) && fifo_wr_n)); // R7
endmodule

// File: tb/usb_fifo_streamer_test.sv
module usb_fifo_streamer_test;
    localparam int CLK_PERIOD = 10;
    localparam int PKT_LOG2   = 4;
    localparam int FRAME_PKTS = 3;
    localparam int FRAME_BYTES = FRAME_PKTS << PKT_LOG2;
    localparam int SETUP  = 2;
    localparam int PULSE  = 3;
    localparam int HOLD   = 1;
    localparam int SETTLE = 3;
    // {latency, capacity, drain gap, start delay}
    localparam logic [31:0] VEC [0:5] = '{
        {8'd1, 8'd64, 8'd1,  8'd0},
        {8'd3, 8'd64, 8'd1,  8'd5},
        {8'd2, 8'd4,  8'd30, 8'd1},
        {8'd1, 8'd1,  8'd12, 8'd2},
        {8'd5, 8'd8,  8'd2,  8'd0},
        {8'd1, 8'd2,  8'd50, 8'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0, frame_go = 1'b0;
    logic frame_busy, frame_done, rd_req, rd_valid = 1'b0;
    logic [5:0] rd_addr;
    logic [7:0] rd_data = 8'd0, fifo_data;
    logic fifo_oe, fifo_wr_n, fifo_full_n;

    int checks = 0, errors = 0, cyc = 0;
    int cap = 64, gap = 1, lat = 1, tag = 0;
    bit mon_clear = 1'b1, force_full = 1'b0;
    int cnt, gap_ctr, pend, req_idx, wr_idx, done_cnt, force_age;
    int setup_run, low_run, post_run;
    bit prev_wr, prev_oe, after_low;
    logic [7:0] low_data;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign fifo_full_n = !(force_full || cnt >= cap);

    usb_fifo_streamer #(
        .DATA_W(8), .PKT_LOG2(PKT_LOG2), .FRAME_PKTS(FRAME_PKTS),
        .SETUP_CLKS(SETUP), .PULSE_CLKS(PULSE), .HOLD_CLKS(HOLD),
        .SETTLE_CLKS(SETTLE), .SYNC_STAGES(2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .frame_busy(frame_busy),
        .frame_done(frame_done), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data), .fifo_data(fifo_data),
        .fifo_oe(fifo_oe), .fifo_wr_n(fifo_wr_n), .fifo_full_n(fifo_full_n)
    );

    function automatic logic [7:0] exp_byte(int idx, int t);
        return 8'(idx * 37 + t * 11 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // Memory and external FIFO model plus write-cycle timing monitor
    always @(negedge clk) begin
        if (mon_clear || !rst_n) begin
            cnt = 0; gap_ctr = 0; pend = 0; req_idx = 0; wr_idx = 0; done_cnt = 0;
            force_age = 0; setup_run = 0; low_run = 0; post_run = 0;
            prev_wr = 1'b1; prev_oe = 1'b0; after_low = 1'b0; rd_valid = 1'b0;
        end else begin
            rd_valid = 1'b0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin rd_valid = 1'b1; rd_data = exp_byte(int'(rd_addr), tag); end
            end
            if (rd_req) begin
                chk(int'(rd_addr) == req_idx, "R3 address order", int'(rd_addr), req_idx);
                req_idx++;
                pend = lat;
            end
            force_age = force_full ? force_age + 1 : 0;
            if (prev_wr && !fifo_wr_n) begin
                chk(fifo_oe && setup_run == SETUP, "R4 setup", setup_run, SETUP);
                chk(cnt < cap && !(force_full && force_age >= 15), "R6 strobe while full", cnt, cap);
                low_run = 1; low_data = fifo_data;
            end else if (!fifo_wr_n) begin
                low_run++;
                if (fifo_data != low_data) chk(1'b0, "R4 data moved", int'(fifo_data), int'(low_data));
            end
            if (!prev_wr && fifo_wr_n) begin
                chk(low_run == PULSE, "R4 pulse width", low_run, PULSE);
                chk(low_data == exp_byte(wr_idx, tag), "R7 byte sequence", int'(low_data), int'(exp_byte(wr_idx, tag)));
                wr_idx++; cnt++; after_low = 1'b1; post_run = 0;
            end
            if (fifo_oe && fifo_wr_n) begin
                if (after_low) post_run++; else setup_run++;
            end
            if (fifo_oe && !frame_busy) chk(1'b0, "R5 enable while idle", 1, 0);
            if (prev_oe && !fifo_oe) begin
                chk(after_low && post_run == HOLD, "R4 hold", post_run, HOLD);
                after_low = 1'b0; setup_run = 0;
            end
            if (frame_done) begin
                done_cnt++;
                chk(wr_idx == FRAME_BYTES, "R8 bytes at done", wr_idx, FRAME_BYTES);
                chk(!frame_busy, "R8 busy at done", int'(frame_busy), 0);
            end
            gap_ctr++;
            if (gap_ctr >= gap) begin gap_ctr = 0; if (cnt > 0) cnt--; end
            prev_wr = fifo_wr_n; prev_oe = fifo_oe;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic start_frame(input int l, input int c, input int g, input int d, input int t);
        tick(); mon_clear = 1'b1; lat = l; cap = c; gap = g; tag = t;
        tick(); mon_clear = 1'b0;
        repeat (d) tick();
        frame_go = 1'b1; tick(); frame_go = 1'b0;
        @(negedge clk);
        chk(frame_busy == 1'b1, "R2 busy after go", int'(frame_busy), 1);
    endtask

    task automatic finish_frame();
        for (int i = 0; i < 30000 && done_cnt == 0; i++) tick();
        repeat (5) tick();
        @(negedge clk);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        chk(wr_idx == FRAME_BYTES, "R9 frame length", wr_idx, FRAME_BYTES);
        chk(req_idx == FRAME_BYTES, "R3 request count", req_idx, FRAME_BYTES);
        chk(!frame_busy && !fifo_oe && fifo_wr_n, "R5 idle bus", int'(fifo_oe), 0);
    endtask

    initial begin
        int held;
        repeat (4) tick();
        @(negedge clk);
        chk(fifo_wr_n && !fifo_oe && !frame_busy && !frame_done && !rd_req,
            "R1 reset outputs", int'({fifo_wr_n, fifo_oe, frame_busy, frame_done, rd_req}), 16);
        tick(); rst_n = 1'b1;
        repeat (3) tick();
        @(negedge clk);
        chk(fifo_wr_n && !fifo_oe && !frame_busy && !rd_req, "R1 after release", int'(frame_busy), 0);

        // Vector table walk
        for (int v = 0; v < 6; v++) begin
            start_frame(int'(VEC[v][31:24]), int'(VEC[v][23:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]), v + 1);
            finish_frame();
        end

        // R2: go while busy is ignored
        start_frame(2, 64, 1, 0, 7);
        repeat (100) tick();
        frame_go = 1'b1; tick(); frame_go = 1'b0;
        finish_frame();
        repeat (200) tick();
        @(negedge clk);
        chk(!frame_busy && wr_idx == FRAME_BYTES, "R2 no restart from busy go", wr_idx, FRAME_BYTES);

        // R6/R7: long forced full window mid-frame
        start_frame(1, 64, 1, 0, 8);
        repeat (60) tick();
        force_full = 1'b1;
        repeat (20) tick();
        @(negedge clk);
        held = wr_idx;
        repeat (200) tick();
        @(negedge clk);
        chk(wr_idx == held, "R6 no writes while full", wr_idx, held);
        chk(frame_busy, "R7 still busy while stalled", int'(frame_busy), 1);
        tick(); force_full = 1'b0;
        finish_frame();

        // R1/R9: reset mid-frame, then a fresh frame from address 0
        start_frame(1, 64, 1, 0, 9);
        repeat (80) tick();
        rst_n = 1'b0; mon_clear = 1'b1;
        tick();
        @(negedge clk);
        chk(fifo_wr_n && !fifo_oe && !frame_busy && !rd_req && !frame_done, "R1 reset mid-frame", int'(frame_busy), 0);
        tick(); rst_n = 1'b1; mon_clear = 1'b0;
        repeat (50) tick();
        @(negedge clk);
        chk(!frame_busy && wr_idx == 0, "R1 abandoned frame", wr_idx, 0);
        start_frame(3, 4, 9, 1, 10);
        finish_frame();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule